// File: doc/BRIEF.md
# Link-side PHY interface controller for a serial bus

This block sits on the link-layer side of the interface between a serial-bus PHY and the link. The two sides share a 2-bit control bus and an 8-bit data bus. The PHY owns both buses by default. The pad ring splits each bidirectional bus into an input, an output and an output enable, and the block works on those three signals.

While the PHY owns the buses, the block watches the control code. It shifts in status transfers and presents them as one word. It also assembles incoming packet bytes at the speed the PHY announces and hands them to a packet sink.

When the PHY grants the bus, the block turns on its drivers. It drives hold while no data is ready, then streams bytes from a transmit source at the speed given for that packet. If another packet is queued, it holds and sends that packet straight after the first one. When nothing more is queued, it drives one idle cycle as a release and gives the buses back to the PHY.

Top module: `sbus_link_phy_if`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), `ctl_oe` and `d_oe` are 0, `stat_valid`, `rx_valid` and `tx_take` are 0, and a grant code seen during reset has no effect.
- R2: The output enables rise only in the cycle after the block samples `ctl_i`=11 (grant) while the PHY owns the bus. A receive or status transfer never turns them on. `ctl_oe` and `d_oe` always switch together.
- R3: A status transfer is a run of STAT_BITS/2 cycles with `ctl_i`=01. Each cycle carries 2 bits on `d_i[1:0]`, and the first pair is the most significant. `stat_valid` pulses for one cycle in the cycle after the last status sample. If the code leaves 01 before the run is complete, no word is delivered.
- R4: `stat_is_read` returns the value `rd_pending` had in the first cycle of that status transfer. Changes to `rd_pending` later in the transfer are ignored.
- R5: A receive starts from the monitoring state with no prior request, when `ctl_i`=10. The first receive cycle carries a speed code on `d_i[1:0]`. Code 00 means 2 bits per cycle on `d_i[1:0]`, 01 means 4 bits on `d_i[3:0]`, and 10 or 11 means 8 bits. The first chunk of each byte is the most significant. Data lines above the active width are ignored.
- R6: Every complete received byte appears once on `rx_data` with `rx_valid`. The final byte also carries `rx_last`, which is issued when `ctl_i` leaves 10. Bits that do not fill a whole byte at the end are dropped.
- R7: While the link owns the bus, it drives `ctl_o`=01 (hold) in the first cycle after a grant and whenever no byte is ready. It drives 10 (transmit) while sending data bits, and it never drives 11.
- R8: Each packet is sent at the width given by `tx_speed` when its first byte is taken (same codes as R5). Data goes out on the low lanes, most significant chunk first, with unused lanes driven 0. `tx_take` pulses once for each byte, only while `tx_ready` is 1.
- R9: If `tx_more` is 1 when the last chunk of a packet is sent, the block drives hold and then sends the next packet without releasing the bus.
- R10: After the last chunk of the last packet, the block drives `ctl_o`=00 with the enables on for exactly one cycle. It then drops both enables and returns to monitoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_i | input | 2 | Control bus as seen at the pad |
| ctl_o | output | 2 | Control code driven by the link |
| ctl_oe | output | 1 | Control bus driver enable |
| d_i | input | 8 | Data bus as seen at the pad |
| d_o | output | 8 | Data driven by the link |
| d_oe | output | 1 | Data bus driver enable |
| rd_pending | input | 1 | A register read request is outstanding |
| stat_word | output | 16 | Assembled status word |
| stat_valid | output | 1 | One-cycle strobe for a new status word |
| stat_is_read | output | 1 | Status word answers a pending read |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_last | output | 1 | Marks the final byte of a packet |
| tx_data | input | 8 | Next byte to transmit |
| tx_ready | input | 1 | `tx_data` holds a byte |
| tx_last | input | 1 | `tx_data` is the final byte of its packet |
| tx_speed | input | 2 | Speed code of the packet about to start |
| tx_more | input | 1 | Another packet is queued behind the current one |
| tx_take | output | 1 | Byte on `tx_data` is consumed this cycle |

## Verification
The hardest case to reach is a transmit session in which several packets are concatenated at different speeds, with the byte source running dry in the middle. That forces a packet back into hold with its speed kept, and the next packet must pick up a fresh speed without any release in between. The bench queues two to three random-length packets with random speeds behind a single grant. In one directed session it also holds `tx_ready` low for several cycles after the grant. It then rebuilds every byte from the lanes the link drove, using the speed the bench expects for that byte, and counts release cycles and enable drops.

// File: rtl/sbus_pkg.sv
// Shared control codes and speed helpers for the link-side PHY interface.
// Assumes the speed code uses 00 for the slowest grade and 01 for the middle grade.
// Any other code selects the full data width.
package sbus_pkg;
    // Codes seen while the PHY owns the bus
    localparam logic [1:0] PHY_IDLE  = 2'b00;
    localparam logic [1:0] PHY_STAT  = 2'b01;
    localparam logic [1:0] PHY_RECV  = 2'b10;
    localparam logic [1:0] PHY_GRANT = 2'b11;
    // Codes driven while the link owns the bus
    localparam logic [1:0] LNK_REL   = 2'b00;
    localparam logic [1:0] LNK_HOLD  = 2'b01;
    localparam logic [1:0] LNK_XMIT  = 2'b10;

    // Active data lanes for a speed code on a bus of width dw
    function automatic int unsigned lane_count(input logic [1:0] spd, input int unsigned dw);
        case (spd)
            2'b00:   return dw / 4;
            2'b01:   return dw / 2;
            default: return dw;
        endcase
    endfunction
endpackage

// File: rtl/sbus_rx_path.sv
// Receive side: watches the PHY-owned control bus. It shifts status pairs into a
// word and assembles packet bytes at the announced speed. Each byte is held back
// by one byte so that the final byte can carry the end mark.
// Assumes STAT_BITS is even and at least 4, and DATA_W is a multiple of 4.
module sbus_rx_path
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned STAT_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [1:0]           ctl_i,
    input  logic [DATA_W-1:0]    d_i,
    input  logic                 rd_pending,
    output logic [STAT_BITS-1:0] stat_word,
    output logic                 stat_valid,
    output logic                 stat_is_read,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 rx_valid,
    output logic                 rx_last
);
    localparam int unsigned STAT_STEPS = STAT_BITS / 2;
    localparam int unsigned SCW        = $clog2(STAT_STEPS + 1);
    localparam int unsigned BCW        = $clog2(DATA_W + 1);
    localparam int unsigned LO_W       = DATA_W / 4;
    localparam int unsigned MID_W      = DATA_W / 2;

    typedef enum logic [1:0] {R_MON, R_STAT, R_RECV} rx_state_e;

    rx_state_e            st;
    logic [STAT_BITS-1:0] sh_stat;
    logic [SCW-1:0]       scnt;
    logic                 rd_q;
    logic [1:0]           spd;
    logic [DATA_W-1:0]    acc;
    logic [DATA_W-1:0]    held;
    logic [DATA_W-1:0]    nb;
    logic                 have;
    logic [BCW-1:0]       bits;
    logic [BCW-1:0]       lanes;
    logic [STAT_BITS-1:0] stat_next;

    // Merge the current data chunk under the partial byte
    always_comb begin
        lanes = BCW'(lane_count(spd, DATA_W));
        case (spd)
            2'b00:   nb = {acc[DATA_W-LO_W-1:0], d_i[LO_W-1:0]};
            2'b01:   nb = {acc[DATA_W-MID_W-1:0], d_i[MID_W-1:0]};
            default: nb = d_i;
        endcase
        stat_next = {sh_stat[STAT_BITS-3:0], d_i[1:0]};
    end

    // Phase tracking, status shifting and byte assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= R_MON;
            sh_stat      <= '0;
            scnt         <= '0;
            rd_q         <= 1'b0;
            spd          <= 2'b00;
            acc          <= '0;
            held         <= '0;
            have         <= 1'b0;
            bits         <= '0;
            stat_word    <= '0;
            stat_valid   <= 1'b0;
            stat_is_read <= 1'b0;
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_last      <= 1'b0;
        end else begin
            stat_valid <= 1'b0;
            rx_valid   <= 1'b0;
            rx_last    <= 1'b0;
            case (st)
                R_MON: begin
                    if (en && ctl_i == PHY_STAT) begin
                        sh_stat <= STAT_BITS'(d_i[1:0]);
                        scnt    <= SCW'(1);
                        rd_q    <= rd_pending;
                        st      <= R_STAT;
                    end else if (en && ctl_i == PHY_RECV) begin
                        spd  <= d_i[1:0];
                        bits <= '0;
                        acc  <= '0;
                        have <= 1'b0;
                        st   <= R_RECV;
                    end
                end
                R_STAT: begin
                    if (ctl_i == PHY_STAT) begin
                        sh_stat <= stat_next;
                        scnt    <= scnt + SCW'(1);
                        if (scnt == SCW'(STAT_STEPS - 1)) begin
                            stat_word    <= stat_next;
                            stat_valid   <= 1'b1;
                            stat_is_read <= rd_q;
                            st           <= R_MON;
                        end
                    end else begin
                        st <= R_MON;
                    end
                end
                default: begin
                    if (ctl_i == PHY_RECV) begin
                        if (int'(bits) + int'(lanes) >= int'(DATA_W)) begin
                            bits <= '0;
                            acc  <= '0;
                            held <= nb;
                            have <= 1'b1;
                            if (have) begin
                                rx_valid <= 1'b1;
                                rx_data  <= held;
                            end
                        end else begin
                            acc  <= nb;
                            bits <= bits + lanes;
                        end
                    end else begin
                        if (have) begin
                            rx_valid <= 1'b1;
                            rx_last  <= 1'b1;
                            rx_data  <= held;
                        end
                        have <= 1'b0;
                        st   <= R_MON;
                    end
                end
            endcase
        end
    end

    AST_STAT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);  // R3
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid);  // R6
    AST_STAT_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_valid) |-> $past(ctl_i) == PHY_STAT);  // R3
endmodule

// File: rtl/sbus_tx_path.sv
// Transmit side: takes the buses after a grant and drives hold until a byte is
// ready. It then sends each byte in chunks at the packet's speed. Between
// concatenated packets it holds; after the final packet it releases for one
// idle cycle.
// Assumes the source keeps tx_speed valid for the first byte of each packet.
module sbus_tx_path
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_i,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              tx_last,
    input  logic [1:0]        tx_speed,
    input  logic              tx_more,
    output logic [1:0]        ctl_o,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] d_o,
    output logic              d_oe,
    output logic              tx_take
);
    localparam int unsigned BCW   = $clog2(DATA_W + 1);
    localparam int unsigned LO_W  = DATA_W / 4;
    localparam int unsigned MID_W = DATA_W / 2;

    typedef enum logic [1:0] {T_MON, T_HOLD, T_XMIT, T_REL} tx_state_e;

    tx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] shifted;
    logic              last_q;
    logic              in_pkt;
    logic [1:0]        spd;
    logic [BCW-1:0]    sent;
    logic [BCW-1:0]    lanes;
    logic              byte_end;
    logic              load;

    // Chunk selection, byte boundary and consume decision
    always_comb begin
        lanes    = BCW'(lane_count(spd, DATA_W));
        byte_end = (int'(sent) + int'(lanes) >= int'(DATA_W));
        load     = tx_ready && ((st == T_HOLD) || (st == T_XMIT && byte_end && !last_q));
        case (spd)
            2'b00: begin
                shifted = sh << LO_W;
                d_o     = DATA_W'(sh[DATA_W-1 -: LO_W]);
            end
            2'b01: begin
                shifted = sh << MID_W;
                d_o     = DATA_W'(sh[DATA_W-1 -: MID_W]);
            end
            default: begin
                shifted = '0;
                d_o     = sh;
            end
        endcase
        if (st != T_XMIT) d_o = '0;
        case (st)
            T_HOLD:  ctl_o = LNK_HOLD;
            T_XMIT:  ctl_o = LNK_XMIT;
            default: ctl_o = LNK_REL;
        endcase
        ctl_oe  = (st != T_MON);
        d_oe    = (st != T_MON);
        tx_take = load;
    end

    // Ownership sequence and byte streaming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= T_MON;
            sh     <= '0;
            last_q <= 1'b0;
            in_pkt <= 1'b0;
            spd    <= 2'b00;
            sent   <= '0;
        end else begin
            case (st)
                T_MON: begin
                    if (ctl_i == PHY_GRANT) st <= T_HOLD;
                end
                T_HOLD: begin
                    if (load) begin
                        sh     <= tx_data;
                        last_q <= tx_last;
                        sent   <= '0;
                        in_pkt <= 1'b1;
                        if (!in_pkt) spd <= tx_speed;
                        st     <= T_XMIT;
                    end
                end
                T_XMIT: begin
                    if (byte_end) begin
                        if (last_q) begin
                            in_pkt <= 1'b0;
                            st     <= tx_more ? T_HOLD : T_REL;
                        end else if (load) begin
                            sh     <= tx_data;
                            last_q <= tx_last;
                            sent   <= '0;
                        end else begin
                            st <= T_HOLD;
                        end
                    end else begin
                        sh   <= shifted;
                        sent <= sent + lanes;
                    end
                end
                default: st <= T_MON;
            endcase
        end
    end

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe |-> ctl_o != 2'b11);  // R7
    AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> $past(ctl_i) == PHY_GRANT);  // R2
    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && ctl_o == LNK_REL) |=> !ctl_oe);  // R10
    AST_TAKE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> tx_ready);  // R8
    AST_HOLD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> ctl_o == LNK_HOLD);  // R7
endmodule

// File: rtl/sbus_link_phy_if.sv
// Top of the link-side PHY interface. It joins the receive monitor and the
// transmit owner. The monitor listens only while the PHY owns the buses.
// Assumes pad-level splitting of each bidirectional bus into in/out/enable.
module sbus_link_phy_if
    import sbus_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned STAT_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ctl_i,
    output logic [1:0]           ctl_o,
    output logic                 ctl_oe,
    input  logic [DATA_W-1:0]    d_i,
    output logic [DATA_W-1:0]    d_o,
    output logic                 d_oe,
    input  logic                 rd_pending,
    output logic [STAT_BITS-1:0] stat_word,
    output logic                 stat_valid,
    output logic                 stat_is_read,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 rx_valid,
    output logic                 rx_last,
    input  logic [DATA_W-1:0]    tx_data,
    input  logic                 tx_ready,
    input  logic                 tx_last,
    input  logic [1:0]           tx_speed,
    input  logic                 tx_more,
    output logic                 tx_take
);
    logic phy_owns;

    // Monitoring is enabled whenever the link is not driving
    always_comb phy_owns = !ctl_oe;

    sbus_rx_path #(.DATA_W(DATA_W), .STAT_BITS(STAT_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(phy_owns), .ctl_i(ctl_i), .d_i(d_i),
        .rd_pending(rd_pending), .stat_word(stat_word), .stat_valid(stat_valid),
        .stat_is_read(stat_is_read), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_last(rx_last)
    );

    sbus_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_last(tx_last), .tx_speed(tx_speed),
        .tx_more(tx_more), .ctl_o(ctl_o), .ctl_oe(ctl_oe), .d_o(d_o),
        .d_oe(d_oe), .tx_take(tx_take)
    );

    AST_ENABLES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe == d_oe);  // R2
endmodule

// File: tb/sbus_link_phy_if_test.sv
module sbus_link_phy_if_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]  phy_ctl = 2'b00;
    logic [7:0]  phy_d = 8'h00;
    logic [1:0]  ctl_i, ctl_o;
    logic [7:0]  d_i, d_o;
    logic        ctl_oe, d_oe, rd_pending = 1'b0;
    logic [15:0] stat_word;
    logic        stat_valid, stat_is_read;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_last;
    logic [7:0]  tx_data;
    logic        tx_ready, tx_last, tx_more, tx_take;
    logic [1:0]  tx_speed;

    // bus resolution between the PHY model and the link
    assign ctl_i = ctl_oe ? ctl_o : phy_ctl;
    assign d_i   = d_oe ? d_o : phy_d;

    sbus_link_phy_if uut (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .ctl_o(ctl_o), .ctl_oe(ctl_oe),
        .d_i(d_i), .d_o(d_o), .d_oe(d_oe), .rd_pending(rd_pending),
        .stat_word(stat_word), .stat_valid(stat_valid), .stat_is_read(stat_is_read),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_last(tx_last),
        .tx_speed(tx_speed), .tx_more(tx_more), .tx_take(tx_take)
    );

    int tests = 0;
    int fails = 0;

    // transmit source queue
    logic [7:0] txq  [0:255];
    logic [1:0] txqs [0:255];
    logic       txql [0:255];
    int qlen = 0;
    int qidx = 0;
    logic stall = 1'b0;

    assign tx_ready = (qidx < qlen) && !stall;
    assign tx_data  = txq[qidx % 256];
    assign tx_last  = txql[qidx % 256];
    assign tx_speed = txqs[qidx % 256];
    assign tx_more  = (qidx < qlen);

    always @(posedge clk) if (rst_n && tx_take) qidx <= qidx + 1;

    // monitors
    logic [7:0] rxg [0:255];
    logic       rxl [0:255];
    int rxn = 0;
    int stn = 0;
    logic [15:0] stw = '0;
    logic stir = 1'b0;
    logic [7:0] txg [0:255];
    int txn = 0;
    int acc = 0, accbits = 0;
    int rel_cnt = 0, hold_cnt = 0, bad_lane = 0, resv = 0, late_oe = 0, stray_oe = 0;
    logic prev_rel = 1'b0;
    logic tx_session = 1'b0;

    function automatic int wid(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rxg[rxn % 256] = rx_data;
                rxl[rxn % 256] = rx_last;
                rxn++;
            end
            if (stat_valid) begin
                stn++;
                stw  = stat_word;
                stir = stat_is_read;
            end
            if (ctl_oe && !tx_session) stray_oe++;
            if (ctl_oe != d_oe) stray_oe++;
            if (prev_rel && ctl_oe) late_oe++;
            prev_rel = ctl_oe && (ctl_o == 2'b00);
            if (ctl_oe) begin
                if (ctl_o == 2'b11) resv++;
                if (ctl_o == 2'b01) hold_cnt++;
                if (ctl_o == 2'b00) rel_cnt++;
                if (ctl_o == 2'b10) begin
                    int w, m;
                    w = wid(txqs[txn % 256]);
                    m = (1 << w) - 1;
                    if ((int'(d_o) & ~m) != 0) bad_lane++;
                    acc = (acc << w) | (int'(d_o) & m);
                    accbits += w;
                    if (accbits >= 8) begin
                        txg[txn % 256] = 8'(acc);
                        txn++;
                        acc = 0;
                        accbits = 0;
                    end
                end
            end
        end
    end

    task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // status transfer of ncyc cycles; ncyc < 8 aborts
    task automatic run_stat(input logic [15:0] w, input logic rdp, input int ncyc);
        int n0;
        n0 = stn;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i == 0) rd_pending = rdp;
            if (i == 1) rd_pending = !rdp;
            phy_ctl = 2'b01;
            phy_d = {6'($urandom), w[15 - 2*i -: 2]};
        end
        @(negedge clk);
        if (ncyc == 8) check(stat_valid == 1'b1, "R3", "status strobe timing", int'(stat_valid), 1);
        phy_ctl = 2'b00;
        repeat (2) @(negedge clk);
        if (ncyc == 8) begin
            check(stn - n0 == 1, "R3", "status word count", stn - n0, 1);
            check(stw == w, "R3", "status word value", int'(stw), int'(w));
            check(stir == rdp, "R4", "read-answer flag", int'(stir), int'(rdp));
        end else begin
            check(stn == n0, "R3", "aborted status delivered", stn - n0, 0);
        end
    endtask

    // receive packet at speed sp; extra adds one partial chunk
    task automatic run_rx(input logic [1:0] sp, input int len, input logic extra);
        logic [7:0] exp_b [0:15];
        int n0, w, m, bad, lasts;
        n0 = rxn;
        w = wid(sp);
        m = (1 << w) - 1;
        @(negedge clk);
        phy_ctl = 2'b10;
        phy_d = {6'($urandom), sp};
        for (int i = 0; i < len; i++) begin
            exp_b[i] = 8'($urandom);
            for (int c = 0; c < 8 / w; c++) begin
                @(negedge clk);
                phy_d = 8'((int'($urandom) & 255 & ~m) | ((int'(exp_b[i]) >> (8 - w*(c+1))) & m));
            end
        end
        if (extra) begin
            @(negedge clk);
            phy_d = 8'($urandom);
        end
        @(negedge clk);
        phy_ctl = 2'b00;
        repeat (3) @(negedge clk);
        check(rxn - n0 == len, "R6", "received byte count", rxn - n0, len);
        bad = 0;
        lasts = 0;
        for (int i = 0; i < len && i < rxn - n0; i++) begin
            if (rxg[(n0 + i) % 256] != exp_b[i]) bad++;
            if (rxl[(n0 + i) % 256]) lasts++;
        end
        check(bad == 0, "R5", "received byte values", bad, 0);
        check(lasts == 1 && rxl[(rxn - 1) % 256] == 1'b1, "R6", "end mark on final byte", lasts, 1);
    endtask

    // transmit session: npk packets, fixspd<0 random speed, stall cycles after grant
    task automatic run_tx(input int npk, input int fixspd, input int stall_cyc);
        int b0, r0, h0, k, bad;
        b0 = qlen;
        r0 = rel_cnt;
        h0 = hold_cnt;
        stall = (stall_cyc > 0);
        for (int p = 0; p < npk; p++) begin
            int len;
            logic [1:0] sp;
            len = 1 + int'($urandom % 4);
            sp = (fixspd >= 0) ? 2'(fixspd) : 2'($urandom % 4);
            for (int i = 0; i < len; i++) begin
                txq[qlen % 256]  = 8'($urandom);
                txqs[qlen % 256] = sp;
                txql[qlen % 256] = (i == len - 1);
                qlen++;
            end
        end
        @(negedge clk);
        phy_ctl = 2'b11;
        tx_session = 1'b1;
        @(negedge clk);
        phy_ctl = 2'b00;
        check(ctl_oe == 1'b1 && d_oe == 1'b1, "R2", "drivers on after grant", int'(ctl_oe), 1);
        check(ctl_o == 2'b01, "R7", "hold right after grant", int'(ctl_o), 1);
        if (stall_cyc > 0) begin
            repeat (stall_cyc) @(negedge clk);
            check(ctl_o == 2'b01 && tx_take == 1'b0, "R7", "hold while source empty", int'(ctl_o), 1);
            stall = 1'b0;
        end
        k = 0;
        while (ctl_oe && k < 2000) begin
            @(negedge clk);
            k++;
        end
        tx_session = 1'b0;
        bad = 0;
        for (int i = b0; i < qlen && i < txn; i++) if (txg[i % 256] != txq[i % 256]) bad++;
        check(txn == qlen, "R8", "transmitted byte count", txn, qlen);
        check(qidx == qlen, "R8", "one take per byte", qidx, qlen);
        check(bad == 0, "R8", "transmitted byte values", bad, 0);
        check(bad_lane == 0, "R8", "unused lanes zero", bad_lane, 0);
        check(resv == 0, "R7", "reserved code driven", resv, 0);
        check(rel_cnt - r0 == 1, "R9", "single release for session", rel_cnt - r0, 1);
        check(hold_cnt - h0 >= npk, "R9", "hold between packets", hold_cnt - h0, npk);
        check(late_oe == 0, "R10", "enables after release", late_oe, 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                fails++;
                tests++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin
            txq[i] = '0;
            txqs[i] = '0;
            txql[i] = 1'b0;
        end
        // R1: reset state, grant during reset ignored
        phy_ctl = 2'b11;
        repeat (3) @(negedge clk);
        check(ctl_oe == 1'b0 && d_oe == 1'b0, "R1", "enables in reset", int'(ctl_oe), 0);
        check(stat_valid == 1'b0 && rx_valid == 1'b0 && tx_take == 1'b0, "R1", "strobes in reset",
              int'(stat_valid) + int'(rx_valid), 0);
        phy_ctl = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ctl_oe == 1'b0, "R1", "no drive after reset", int'(ctl_oe), 0);

        // status transfers
        run_stat(16'hA5C3, 1'b0, 8);
        run_stat(16'h3E71, 1'b1, 8);
        run_stat(16'hFFFF, 1'b1, 3);
        run_stat(16'h0001, 1'b0, 8);

        // receive at each speed, directed then random
        run_rx(2'b00, 3, 1'b0);
        run_rx(2'b01, 2, 1'b0);
        run_rx(2'b10, 5, 1'b0);
        run_rx(2'b11, 1, 1'b0);
        run_rx(2'b00, 2, 1'b1);
        run_rx(2'b01, 1, 1'b1);
        for (int i = 0; i < 6; i++) run_rx(2'($urandom % 4), 1 + int'($urandom % 6), 1'b0);
        check(stray_oe == 0, "R2", "no drive without grant", stray_oe, 0);

        // transmit sessions
        run_tx(1, 0, 0);
        run_tx(1, 1, 0);
        run_tx(1, 2, 0);
        run_tx(2, -1, 5);
        for (int i = 0; i < 5; i++) run_tx(1 + int'($urandom % 3), -1, int'($urandom % 3));

        // back to receiving after transmit
        run_rx(2'b01, 3, 1'b0);
        check(stray_oe == 0, "R10", "monitoring after release", stray_oe, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule